// File: doc/BRIEF.md
# Time-of-Year Seconds Counter

This block keeps wall-clock time as a count of seconds in a slow clock domain driven by a 32.768 kHz crystal. That domain keeps running while the main system clock is stopped. A programmable prescaler divides the slow clock into ticks, and each tick advances a 32-bit seconds count. Software reaches the block through a simple register port clocked by the fast bus clock.

A new count or a new prescaler value is written on the bus side. The bus side holds the value in a register and passes a toggle request across a two-flop synchroniser. The slow side applies the value and returns an acknowledge toggle along the same kind of path. A busy flag for each register stays set until its acknowledge comes back, and software polls that flag instead of stalling the bus. The count is read at a different address from the one it is written at. That read address returns a copy that has been synchronised into the bus domain. The copy is only refreshed while the slow value is stable, so a partly updated value is never returned.

Top module: `toy_seconds_counter`

## Requirements
- R1: The prescaler divides the slow clock by the trim value plus one. The trim register (address 0, bits [15:0]) resets to 32767, which gives one tick per second, and reads back the last accepted value.
- R2: Each tick adds one to the seconds count. A count of 0xFFFFFFFF wraps to 0.
- R3: Register addresses: 0 is trim, 1 is the count write port, 2 is the count read port and 3 is control/status. Reading address 1 returns 0.
- R4: Status bit 3 (count busy) reads 1 from the bus cycle after an accepted write to address 1 until the slow domain has loaded that value. It then returns to 0.
- R5: Status bit 2 (trim busy) behaves the same way for writes to address 0. A write to address 0 or address 1 that arrives while its own busy bit is set is ignored.
- R6: Status bit 0 is the read/write count enable and resets to 0. Status bit 1 is read-only and becomes 1 once edges of the slow clock have been seen in the bus domain.
- R7: A count write loads the value and clears the prescaler. The first increment after the load comes trim+1 slow cycles later.
- R8: While the enable bit is 0, the count and the prescaler hold their values. A count write still loads the count.
- R9: Address 2 returns a bus-domain copy of the count that is captured only after the slow value has settled. It follows every change of the count with a fixed delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Fast bus clock |
| slowClk | input | 1 | 32.768 kHz counting clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |

## Verification
The counting function is tried with two trim values, 3 and 7. The bench counts slow cycles between successive changes of the read port, so a divide by trim is told apart from a divide by trim+1. A count loaded while counting is running checks that the prescaler is cleared: without the clear, the first interval after the load would be shorter than the later ones. Loading 0xFFFFFFFF tests the wrap. A pair of back-to-back writes, with the second arriving while busy is set, must leave the first value in place. Holding the enable bit at 0 must freeze the read value even while the slow clock runs.

// File: rtl/toy_pkg.sv
package toy_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADR_TRIM   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CNT_WR = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT_RD = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 2'd3;

  // bus side -> slow side strobes (toggles and level)
  typedef struct packed {
    logic cntTgl;
    logic trimTgl;
    logic enable;
  } toyReqT;

  // slow side -> bus side toggles
  typedef struct packed {
    logic cntAck;
    logic trimAck;
    logic shadowTgl;
    logic beat;
  } toyAckT;
endpackage

// File: rtl/toy_sync2.sv
module toy_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/toy_bus_ctrl.sv
module toy_bus_ctrl
  import toy_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16,
  parameter logic [PRE_W-1:0] TRIM_INIT = '1
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  output toyReqT            req,
  output logic [CNT_W-1:0]  cntHold,
  output logic [PRE_W-1:0]  trimHold,
  input  toyAckT            ack,
  input  logic [CNT_W-1:0]  shadowCnt
);
  localparam int ACK_W = $bits(toyAckT);

  toyAckT ackS;
  logic [ACK_W-1:0] ackSBits;
  logic shTglQ, beatQ, detected;
  logic [CNT_W-1:0] rdSnap;
  logic cntBusy, trimBusy, wrCnt, wrTrim, wrStat;
  logic unusedWrBits;

  toy_sync2 #(.W(ACK_W)) u_ackSync (
    .clk(busClk), .rstN(rstN), .d(ack), .q(ackSBits)
  );
  assign ackS = toyAckT'(ackSBits);

  assign cntBusy  = req.cntTgl  != ackS.cntAck;
  assign trimBusy = req.trimTgl != ackS.trimAck;
  assign wrCnt    = busWrEn && busAddr == ADR_CNT_WR && !cntBusy;
  assign wrTrim   = busWrEn && busAddr == ADR_TRIM   && !trimBusy;
  assign wrStat   = busWrEn && busAddr == ADR_STAT;
  assign unusedWrBits = ^busWrData[CNT_W-1:PRE_W];

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      req      <= '0;
      cntHold  <= '0;
      trimHold <= TRIM_INIT;
      shTglQ   <= 1'b0;
      beatQ    <= 1'b0;
      detected <= 1'b0;
      rdSnap   <= '0;
    end else begin
      if (wrCnt) begin
        cntHold    <= busWrData;
        req.cntTgl <= ~req.cntTgl;
      end
      if (wrTrim) begin
        trimHold    <= busWrData[PRE_W-1:0];
        req.trimTgl <= ~req.trimTgl;
      end
      if (wrStat) req.enable <= busWrData[0];
      shTglQ <= ackS.shadowTgl;
      if (shTglQ != ackS.shadowTgl) rdSnap <= shadowCnt;
      beatQ <= ackS.beat;
      if (beatQ != ackS.beat) detected <= 1'b1;
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADR_TRIM:   busRdData[PRE_W-1:0] = trimHold;
      ADR_CNT_RD: busRdData = rdSnap;
      ADR_STAT:   busRdData[3:0] = {cntBusy, trimBusy, detected, req.enable};
      default:    busRdData = '0;
    endcase
  end

  // R4: an accepted count write raises the busy flag at once
  a_r4_busy_set: assert property (@(posedge busClk) disable iff (!rstN)
    (busWrEn && busAddr == ADR_CNT_WR && !cntBusy) |=> cntBusy);
  // R5: count writes while busy leave the held value and request untouched
  a_r5_cnt_ignored: assert property (@(posedge busClk) disable iff (!rstN)
    (busWrEn && busAddr == ADR_CNT_WR && cntBusy) |=> ($stable(cntHold) && $stable(req.cntTgl)));
  // R5: trim writes while busy are dropped
  a_r5_trim_ignored: assert property (@(posedge busClk) disable iff (!rstN)
    (busWrEn && busAddr == ADR_TRIM && trimBusy) |=> ($stable(trimHold) && $stable(req.trimTgl)));
  // R6: clock detect is sticky once set
  a_r6_detect_sticky: assert property (@(posedge busClk) disable iff (!rstN)
    detected |=> detected);
endmodule

// File: rtl/toy_slow_path.sv
module toy_slow_path
  import toy_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16,
  parameter logic [PRE_W-1:0] TRIM_INIT = '1
) (
  input  logic             slowClk,
  input  logic             rstN,
  input  toyReqT           req,
  input  logic [CNT_W-1:0] cntHold,
  input  logic [PRE_W-1:0] trimHold,
  output toyAckT           ack,
  output logic [CNT_W-1:0] shadowCnt
);
  localparam int REQ_W = $bits(toyReqT);

  toyReqT reqS;
  logic [REQ_W-1:0] reqSBits;
  logic cntReqQ, trimReqQ, loadCnt, loadTrim, shTgl, beat;
  logic [PRE_W-1:0] pre, trim;
  logic [CNT_W-1:0] count;

  toy_sync2 #(.W(REQ_W)) u_reqSync (
    .clk(slowClk), .rstN(rstN), .d(req), .q(reqSBits)
  );
  assign reqS = toyReqT'(reqSBits);

  assign loadCnt  = reqS.cntTgl  != cntReqQ;
  assign loadTrim = reqS.trimTgl != trimReqQ;

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      cntReqQ   <= 1'b0;
      trimReqQ  <= 1'b0;
      pre       <= '0;
      trim      <= TRIM_INIT;
      count     <= '0;
      shadowCnt <= '0;
      shTgl     <= 1'b0;
      beat      <= 1'b0;
    end else begin
      cntReqQ  <= reqS.cntTgl;
      trimReqQ <= reqS.trimTgl;
      beat     <= ~beat;
      if (loadTrim) trim <= trimHold;
      if (loadCnt) begin
        count <= cntHold;
        pre   <= '0;
      end else if (reqS.enable) begin
        if (pre >= trim) begin
          pre   <= '0;
          count <= count + 1'b1;
        end else begin
          pre <= pre + 1'b1;
        end
      end
      shadowCnt <= count;
      if (shadowCnt != count) shTgl <= ~shTgl;
    end
  end

  assign ack = '{cntAck: cntReqQ, trimAck: trimReqQ, shadowTgl: shTgl, beat: beat};

  // R7: a load takes the held value and clears the prescaler
  a_r7_load: assert property (@(posedge slowClk) disable iff (!rstN)
    loadCnt |=> (count == $past(cntHold) && pre == '0));
  // R2: a tick advances the count by one (wrapping)
  a_r2_tick: assert property (@(posedge slowClk) disable iff (!rstN)
    (!loadCnt && reqS.enable && pre >= trim) |=> count == $past(count) + 1'b1);
  // R8: disabled counting holds both registers
  a_r8_hold: assert property (@(posedge slowClk) disable iff (!rstN)
    (!loadCnt && !reqS.enable) |=> ($stable(count) && $stable(pre)));
  // R9: the shadow copy follows the count one cycle later
  a_r9_shadow: assert property (@(posedge slowClk) disable iff (!rstN)
    1'b1 |=> shadowCnt == $past(count));
endmodule

// File: rtl/toy_seconds_counter.sv
module toy_seconds_counter
  import toy_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16,
  parameter int RESET_TRIM = 32767
) (
  input  logic              busClk,
  input  logic              slowClk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData
);
  localparam logic [PRE_W-1:0] TRIM_INIT = PRE_W'(RESET_TRIM);

  toyReqT req;
  toyAckT ack;
  logic [CNT_W-1:0] cntHold, shadowCnt;
  logic [PRE_W-1:0] trimHold;

  toy_bus_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .TRIM_INIT(TRIM_INIT)) u_ctrl (
    .busClk(busClk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .req(req),
    .cntHold(cntHold), .trimHold(trimHold), .ack(ack), .shadowCnt(shadowCnt)
  );

  toy_slow_path #(.CNT_W(CNT_W), .PRE_W(PRE_W), .TRIM_INIT(TRIM_INIT)) u_slow (
    .slowClk(slowClk), .rstN(rstN), .req(req), .cntHold(cntHold),
    .trimHold(trimHold), .ack(ack), .shadowCnt(shadowCnt)
  );
endmodule

// File: tb/toy_seconds_counter_tb.sv
module toy_seconds_counter_tb;
  logic busClk = 1'b0, slowClk = 1'b0, rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [31:0] busWrData = '0, busRdData;
  int checks = 0, failures = 0, slowTick = 0;
  bit finished = 1'b0;

  always #10 busClk = ~busClk;
  always #100 slowClk = ~slowClk;
  always @(posedge slowClk) slowTick++;

  toy_seconds_counter u_dut (
    .busClk(busClk), .slowClk(slowClk), .rstN(rstN), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge busClk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge busClk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge busClk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      busRead(2'd3, s);
      if (s[3:2] == 2'b00) return;
    end
    check("R4 busy never cleared", s[3:2], 2'b00);
  endtask

  // waits until the read port differs from prev; returns value and slow tick
  task automatic waitChange(input logic [31:0] prev, output logic [31:0] v, output int t);
    for (int i = 0; i < 20000; i++) begin
      busRead(2'd2, v);
      if (v != prev) begin t = slowTick; return; end
    end
    t = slowTick;
  endtask

  task automatic tReset();
    logic [31:0] d;
    busRead(2'd3, d);
    check("R6 enable resets to 0", {31'd0, d[0]}, 32'd0);
    check("R4/R5 busy bits at reset", {30'd0, d[3:2]}, 32'd0);
    busRead(2'd2, d);
    check("R9 count reads 0 after reset", d, 32'd0);
    busRead(2'd0, d);
    check("R1 trim resets to 32767", d, 32'd32767);
    repeat (10) @(posedge slowClk);
    busRead(2'd3, d);
    check("R6 clock detect set", {31'd0, d[1]}, 32'd1);
  endtask

  task automatic tTrim();
    logic [31:0] d;
    busWrite(2'd0, 32'd3);
    busWrite(2'd0, 32'd9);      // arrives while trim busy: dropped
    busRead(2'd3, d);
    check("R5 trim busy after write", {31'd0, d[2]}, 32'd1);
    waitIdle();
    busRead(2'd0, d);
    check("R5 second trim write ignored", d, 32'd3);
  endtask

  task automatic tCountWrite();
    logic [31:0] d;
    busWrite(2'd1, 32'd100);
    busRead(2'd3, d);
    check("R4 count busy after write", {31'd0, d[3]}, 32'd1);
    busWrite(2'd1, 32'd200);    // ignored: busy
    waitIdle();
    repeat (4) @(posedge slowClk);
    busRead(2'd2, d);
    check("R5 count write while busy ignored", d, 32'd100);
    busRead(2'd1, d);
    check("R3 write port reads 0", d, 32'd0);
    repeat (30) @(posedge slowClk);
    busRead(2'd2, d);
    check("R8 disabled count holds", d, 32'd100);
  endtask

  task automatic tPeriod(input int trimVal);
    logic [31:0] v0, v1, v2;
    int t0, t1, t2;
    busRead(2'd2, v0);
    waitChange(v0, v1, t1);
    waitChange(v1, v2, t2);
    check("R2 increments by one", v2, v1 + 32'd1);
    check("R1 tick period trim+1", t2 - t1, trimVal + 1);
    t0 = t2;
    waitChange(v2, v1, t1);
    check("R1 second interval", t1 - t0, trimVal + 1);
  endtask

  task automatic tLoadRunning();
    logic [31:0] v, w;
    int t0, t1;
    busRead(2'd2, v);
    waitChange(v, w, t0);        // align to a tick
    repeat (2) @(posedge slowClk); // load mid-period
    busWrite(2'd1, 32'd1000);
    for (int i = 0; i < 20000; i++) begin
      busRead(2'd2, v);
      if (v == 32'd1000) break;
    end
    check("R9 loaded value visible", v, 32'd1000);
    t0 = slowTick;
    waitChange(v, w, t1);
    check("R7 first increment after load", t1 - t0, 4);
    check("R7 value after first tick", w, 32'd1001);
  endtask

  task automatic tWrap();
    logic [31:0] v, w;
    int t;
    busWrite(2'd1, 32'hFFFF_FFFF);
    for (int i = 0; i < 20000; i++) begin
      busRead(2'd2, v);
      if (v == 32'hFFFF_FFFF) break;
    end
    check("R2 max value loaded", v, 32'hFFFF_FFFF);
    waitChange(v, w, t);
    check("R2 wraps to zero", w, 32'd0);
  endtask

  task automatic tDisable();
    logic [31:0] v, w;
    busWrite(2'd3, 32'd0);
    repeat (6) @(posedge slowClk);
    busRead(2'd2, v);
    repeat (40) @(posedge slowClk);
    busRead(2'd2, w);
    check("R8 hold when disabled", w, v);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge busClk);
    rstN = 1'b1;
    tReset();
    tTrim();
    tCountWrite();
    busWrite(2'd3, 32'd1);      // R6 enable
    tPeriod(3);
    tLoadRunning();
    busWrite(2'd0, 32'd7);
    waitIdle();
    tPeriod(7);
    busWrite(2'd0, 32'd3);
    waitIdle();
    tWrap();
    tDisable();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule